// File: doc/BRIEF.md
# Serial Key-Code Display Shifter

When the dialer accepts a key, this block shifts a 4-bit code for that key out on two open-drain lines, a data line and a clock line. An external display driver or microcontroller reads them. The block never drives a line high. Each output is a pull-low enable, so `1` means "line pulled low" and `0` means "line released (high)". The serial clock rate comes from an external clock-enable `tick`; with a suitable tick rate the serial clock runs at about 2.4 kHz. Each released or pulled phase of the serial clock lasts from one tick to the next.

The key is presented as a key identifier on `key` with a one-cycle `load` strobe. The block turns that identifier into a display code that is not plain BCD: zero and the function keys use codes above 9. It then emits the code most significant bit first. The data line changes only while the serial clock is released, and the receiver samples it on the falling edge of the serial clock. A request that arrives while a transfer is in progress is parked in a one-entry hold slot and sent immediately after the current code.

The state machine has four states:
- `S_IDLE`: both lines released.
- `S_SETUP`: clock released, data driven.
- `S_LOW`: clock pulled low, data held.
- `S_TAIL`: clock released, data released, after the fourth bit.

It has these transitions:
- IDLE→SETUP: a launch, meaning a valid load.
- SETUP→LOW: on a tick.
- LOW→SETUP: on a tick when bits remain. The next bit is shifted up.
- LOW→TAIL: on a tick after the fourth bit.
- TAIL→SETUP: on a tick when a held or simultaneous request is pending.
- TAIL→IDLE: on a tick with nothing pending.

Top module: `key_code_serializer`

## Requirements
- R1: Key identifiers 1 to 9 on `key` are sent as their own binary value (0001 to 1001).
- R2: Key identifier 0 is sent as 1010. Identifier 10 (star) is sent as 1101, 11 (hash) as 1100, 12 (flash) as 1011 and 13 (pause) as 1110.
- R3: Bits go out most significant first. A bit of 1 leaves `data_pull`=0 and a bit of 0 sets `data_pull`=1. The bit is valid when `clk_pull` goes from 0 to 1.
- R4: `data_pull` does not change while `clk_pull` stays 1. It changes only while the serial clock is released.
- R5: Every accepted key produces exactly four `clk_pull` pulses.
- R6: `busy` is 1 from the cycle after an accepted load until the final released phase ends with nothing pending. While `busy` is 0, both pull outputs are 0.
- R7: A valid load while `busy` is 1 is held and sent directly after the current code, in arrival order.
- R8: While a request is held, further loads are ignored until the held one has been taken.
- R9: Key identifiers 14 and 15 are ignored: no pulses, and `busy` stays 0.
- R10: A valid load in the same cycle as the tick that ends the final released phase starts the new code at once. `busy` does not drop, and that code's first bit is on `data_pull` in the next cycle.
- R11: After reset both pull outputs and `busy` are 0. `clk_pull` changes only on a cycle following a `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-enable marking each serial clock phase boundary |
| load | input | 1 | One-cycle request to send the key on `key` |
| key | input | KEY_W | Key identifier (0-9 digits, 10 star, 11 hash, 12 flash, 13 pause) |
| data_pull | output | 1 | Pull-low enable for the serial data line |
| clk_pull | output | 1 | Pull-low enable for the serial clock line |
| busy | output | 1 | Transfer in progress or request held |

## Verification
Two events can fall in the same cycle: the tick that closes the final released phase of one code, and a fresh load. The bench counts the serial clock releases of the running code. It then raises `load` exactly in the cycle whose clock edge carries the closing tick. It judges the result by whether `busy` holds at 1 and the next cycle already shows the new code's first bit on the data line. The monitor then decodes the complete new code.

// File: rtl/keyser_pkg.sv
package keyser_pkg;
    localparam int KEY_W  = 4;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SETUP,
        S_LOW,
        S_TAIL
    } ser_state_t;
endpackage

// File: rtl/key_code_encoder.sv
module key_code_encoder
    import keyser_pkg::*;
#(
    parameter int KW = KEY_W,
    parameter int CW = CODE_W
) (
    input  logic [KW-1:0] key,
    output logic [CW-1:0] code,
    output logic          ok
);
    always_comb begin
        ok   = 1'b1;
        code = '0;
        if (key >= KW'(1) && key <= KW'(9)) begin
            code = CW'(key);
        end else begin
            case (key)
                KW'(0):  code = CW'(4'b1010);
                KW'(10): code = CW'(4'b1101);
                KW'(11): code = CW'(4'b1100);
                KW'(12): code = CW'(4'b1011);
                KW'(13): code = CW'(4'b1110);
                default: begin
                    ok   = 1'b0;
                    code = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/key_hold_slot.sv
module key_hold_slot #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic         full,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (take) begin
            full <= push;
            if (push) dout <= din;
        end else if (push && !full) begin
            full <= 1'b1;
            dout <= din;
        end
    end
endmodule

// File: rtl/key_code_serializer.sv
module key_code_serializer
    import keyser_pkg::*;
#(
    parameter int KEY_BITS  = KEY_W,
    parameter int CODE_BITS = CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                load,
    input  logic [KEY_BITS-1:0] key,
    output logic                data_pull,
    output logic                clk_pull,
    output logic                busy
);
    localparam int CNT_W = (CODE_BITS > 1) ? $clog2(CODE_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_BITS - 1);

    ser_state_t           state;
    logic [CODE_BITS-1:0] shreg;
    logic [CNT_W-1:0]     bitcnt;

    logic [CODE_BITS-1:0] new_code, held_code, src_code;
    logic                 new_ok, held_full;
    logic                 load_ok, start_pt, launch, take, push;

    key_code_encoder #(.KW(KEY_BITS), .CW(CODE_BITS)) u_enc (
        .key  (key),
        .code (new_code),
        .ok   (new_ok)
    );

    key_hold_slot #(.W(CODE_BITS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .take  (take),
        .din   (new_code),
        .full  (held_full),
        .dout  (held_code)
    );

    // launch decision: held request has priority over a fresh one
    assign load_ok  = load && new_ok;
    assign start_pt = (state == S_IDLE) || ((state == S_TAIL) && tick);
    assign launch   = start_pt && (held_full || load_ok);
    assign src_code = held_full ? held_code : new_code;
    assign take     = launch && held_full;
    assign push     = load_ok && !(launch && !held_full);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (launch) begin
                        state  <= S_SETUP;
                        shreg  <= src_code;
                        bitcnt <= '0;
                    end
                end
                S_SETUP: begin
                    if (tick) state <= S_LOW;
                end
                S_LOW: begin
                    if (tick) begin
                        if (bitcnt == LAST_BIT) begin
                            state <= S_TAIL;
                        end else begin
                            state  <= S_SETUP;
                            shreg  <= {shreg[CODE_BITS-2:0], 1'b0};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                end
                S_TAIL: begin
                    if (tick) begin
                        if (launch) begin
                            state  <= S_SETUP;
                            shreg  <= src_code;
                            bitcnt <= '0;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        data_pull = 1'b0;
        clk_pull  = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_SETUP: data_pull = !shreg[CODE_BITS-1];
            S_LOW: begin
                data_pull = !shreg[CODE_BITS-1];
                clk_pull  = 1'b1;
            end
            S_TAIL:  ;
        endcase
        busy = (state != S_IDLE) || held_full;
    end
endmodule

// File: rtl/key_code_serializer_chk.sv
module key_code_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic data_pull,
    input logic clk_pull,
    input logic busy
);
    a_r4_data_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_pull && $past(clk_pull)) |-> $stable(data_pull))
        else $error("R4 data moved while clock pulled");

    a_r6_quiet_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!clk_pull && !data_pull))
        else $error("R6 line pulled while not busy");

    a_r11_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_pull) |-> $past(tick))
        else $error("R11 clock line moved without tick");

    a_r5_pulse_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pull |-> busy)
        else $error("R5 pulse outside a transfer");

    a_r5_pulse_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_pull) |-> $past(busy))
        else $error("R5 pulse without preceding setup");
endmodule

bind key_code_serializer key_code_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .data_pull (data_pull),
    .clk_pull  (clk_pull),
    .busy      (busy)
);

// File: tb/sim_key_code_serializer.sv
module sim_key_code_serializer;
    localparam int TICK_P = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load;
    logic [3:0] key;
    logic [2:0] div;
    logic       tick;
    logic       data_pull, clk_pull, busy;

    int vectors = 0;
    int miscompares = 0;
    int received = 0;
    int cyc = 0;
    logic [3:0] exp_q[$];

    always #5 clk = ~clk;

    assign tick = (div == 3'(TICK_P - 1));
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div <= '0;
        else        div <= tick ? 3'd0 : div + 3'd1;
    end

    key_code_serializer u0 (
        .clk (clk), .rst_n (rst_n), .tick (tick), .load (load), .key (key),
        .data_pull (data_pull), .clk_pull (clk_pull), .busy (busy)
    );

    function automatic logic [3:0] code_of(int k);
        case (k)
            0:  return 4'b1010;
            10: return 4'b1101;
            11: return 4'b1100;
            12: return 4'b1011;
            13: return 4'b1110;
            default: return 4'(k);
        endcase
    endfunction

    function automatic void check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endfunction

    // monitor: decode bits at each falling edge of the serial clock line
    logic       prev_cp = 1'b0;
    logic       cur_bit = 1'b0;
    logic [3:0] bits = '0;
    int         nbits = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (clk_pull && !prev_cp) begin
                cur_bit = !data_pull;
                bits    = {bits[2:0], cur_bit};
                nbits++;
                if (nbits == 4) begin   // R5: codes are framed in groups of four pulses
                    nbits = 0;
                    received++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 unexpected transfer", bits, -1);
                    end else begin
                        logic [3:0] e;
                        e = exp_q.pop_front();
                        check(bits == e, "R1/R2/R3 code", bits, e);
                    end
                end
            end else if (clk_pull && prev_cp && (!data_pull != cur_bit)) begin
                check(1'b0, "R4 data moved during low", !data_pull, cur_bit);
            end
            prev_cp = clk_pull;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic send(int k);
        @(negedge clk);
        load = 1'b1;
        key  = 4'(k);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || exp_q.size() != 0);
    endtask

    initial begin
        rst_n = 1'b0;
        load  = 1'b0;
        key   = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(clk_pull == 1'b0, "R11 reset clk_pull", clk_pull, 0);
        check(data_pull == 1'b0, "R11 reset data_pull", data_pull, 0);
        check(busy == 1'b0, "R11 reset busy", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R2: every key identifier
        for (int k = 0; k < 14; k++) begin
            exp_q.push_back(code_of(k));
            send(k);
            if (k == 1) check(busy == 1'b1, "R6 busy after load", busy, 1);
            wait_idle();
        end
        check(data_pull == 1'b0 && clk_pull == 1'b0, "R6 lines released when idle",
              {data_pull, clk_pull}, 0);

        // R9: identifiers 14 and 15 ignored
        send(14);
        send(15);
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R9 busy after invalid keys", busy, 0);

        // R7 / R8: held request, third load dropped
        exp_q.push_back(code_of(5));
        exp_q.push_back(code_of(0));
        @(negedge clk);
        load = 1'b1; key = 4'd5;
        @(negedge clk);
        key = 4'd0;
        @(negedge clk);
        key = 4'd13;
        @(negedge clk);
        load = 1'b0;
        check(busy == 1'b1, "R7 busy with held request", busy, 1);
        wait_idle();
        check(received == 16, "R8 transfers after hold", received, 16);

        // R10: load in the same cycle as the closing tick
        exp_q.push_back(code_of(7));
        exp_q.push_back(code_of(3));
        send(7);
        begin
            int   rel = 0;
            logic pv  = clk_pull;
            while (rel < 4) begin
                @(negedge clk);
                if (pv && !clk_pull) rel++;
                pv = clk_pull;
            end
            while (!tick) @(negedge clk);
            load = 1'b1;
            key  = 4'd3;
            @(negedge clk);
            load = 1'b0;
            check(busy == 1'b1, "R10 busy held", busy, 1);
            check(clk_pull == 1'b0, "R10 clock released in setup", clk_pull, 0);
            check(data_pull == 1'b1, "R10 first bit present", data_pull, 1);
        end
        wait_idle();

        check(received == 18, "R5 total transfers", received, 18);
        check(exp_q.size() == 0, "R8 no leftover codes", exp_q.size(), 0);
        check(nbits == 0, "R5 no partial code", nbits, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule